// File: doc/BRIEF.md
# CAN Bus-On Recovery Sequencer

This block decides when a CAN controller may rejoin the bus after it leaves a reset condition. It follows the received bit stream at each bit-sample strobe and counts bus-free occurrences. A bus-free occurrence is a run of 11 consecutive recessive bits. Only when the required number of occurrences has been seen does it raise the bus-on flag.

The number of occurrences needed depends on what caused the last reset. After a hardware reset, or after the reset-mode flag was raised from outside (a software reset), one occurrence is enough. After an internal bus-off event, 128 occurrences are required. The block stores the cause and uses it each time the reset-mode flag is cleared. It reports bus-on, and it reports a recovery-in-progress status while it waits.

Top module: `can_rejoin_seq`

## Requirements
- R1: While `reset_mode_i` is 1, and in every cycle after `rst_n` is released until `reset_mode_i` falls, both `bus_on_o` and `recovering_o` are 0 whatever the strobe and receive inputs do.
- R2: After a hardware reset and a clear of `reset_mode_i`, `bus_on_o` rises in the cycle after the strobe that samples the 11th consecutive recessive bit (`rx_bit_i` = 1 is recessive, 0 is dominant). After only 10 such bits it stays 0.
- R3: A dominant bit sampled during recovery restarts the recessive run, so 11 fresh recessive bits are needed after it to complete an occurrence.
- R4: After a pulse on `bus_off_i`, recovery needs 128 bus-free occurrences. After 127 occurrences plus 10 recessive bits, `bus_on_o` is still 0. One further recessive bit raises it.
- R5: A dominant bit between occurrences does not discard occurrences already completed.
- R6: Raising `reset_mode_i` while in recovery or on the bus, with no bus-off pulse, marks the cause as a software reset, so the next recovery needs a single occurrence.
- R7: Raising `reset_mode_i` during a recovery abandons it. In the next cycle `recovering_o` and `bus_on_o` are both 0, and no occurrences are carried into the following recovery.
- R8: The recovery counters advance only on cycles with `bit_strobe_i` = 1. Cycles without a strobe have no effect on progress, whatever `rx_bit_i` is.
- R9: `recovering_o` is 1 from the cycle after `reset_mode_i` falls until `bus_on_o` rises. The two outputs are never 1 together.
- R10: A pulse on `bus_off_i` while on the bus makes `bus_on_o` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reset_mode_i | input | 1 | Reset-mode flag; 1 holds the controller off the bus |
| bus_off_i | input | 1 | Single-cycle pulse when the controller enters bus-off |
| bit_strobe_i | input | 1 | Bit-sample strobe, one cycle per bit time |
| rx_bit_i | input | 1 | Received bit, 1 = recessive, 0 = dominant |
| bus_on_o | output | 1 | Controller may take part in bus traffic |
| recovering_o | output | 1 | Waiting for bus-free occurrences |

## Verification
The assertions assume the following about the inputs:
- `bus_off_i` is a single-cycle pulse.
- `bit_strobe_i` is high for one clock per bit.
- `rx_bit_i` is only meaningful on strobe cycles.

The stimulus therefore raises each strobe for exactly one clock, between falling edges. It pulses bus-off for one clock. It changes `rx_bit_i` freely in cycles without a strobe, which exercises the claim that those cycles have no effect. The sweep over run lengths and the long bus-off recovery stay within these rules, so every expected value follows from counting strobed bits alone.

// File: rtl/can_rejoin_pkg.sv
package can_rejoin_pkg;
  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_RECOVER = 2'd1,
    ST_ONLINE  = 2'd2
  } rejoin_state_e;

  typedef enum logic {
    CAUSE_SHORT = 1'b0,
    CAUSE_LONG  = 1'b1
  } rejoin_cause_e;
endpackage

// File: rtl/can_idle_run.sv
module can_idle_run #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic rx_bit_i,
  output logic occ_tick_o
);
  localparam int RUN_W = $clog2(IDLE_BITS);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_BITS - 1);

  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    run_d      = run_q;
    occ_tick_o = 1'b0;
    if (clr_i) begin
      run_d = '0;
    end else if (en_i) begin
      if (!rx_bit_i) begin
        run_d = '0;
      end else if (run_q == RUN_LAST) begin
        run_d      = '0;
        occ_tick_o = 1'b1;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(run_q));

  // R3
  dominant_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !rx_bit_i) |=> (run_q == '0));
endmodule

// File: rtl/can_occ_count.sv
module can_occ_count #(
  parameter int MAX_OCC = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       tick_i,
  input  logic [$clog2(MAX_OCC+1)-1:0] target_i,
  output logic                       hit_o
);
  localparam int OCC_W = $clog2(MAX_OCC + 1);

  logic [OCC_W-1:0] occ_q, occ_d;

  always_comb begin
    occ_d = occ_q;
    hit_o = tick_i && ((occ_q + 1'b1) == target_i);
    if (clr_i)       occ_d = '0;
    else if (tick_i) occ_d = occ_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  // R5
  occ_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(occ_q));
endmodule

// File: rtl/can_rejoin_seq.sv
module can_rejoin_seq
  import can_rejoin_pkg::*;
#(
  parameter int IDLE_BITS  = 11,
  parameter int SHORT_OCC  = 1,
  parameter int LONG_OCC   = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_mode_i,
  input  logic bus_off_i,
  input  logic bit_strobe_i,
  input  logic rx_bit_i,
  output logic bus_on_o,
  output logic recovering_o
);
  localparam int MAX_OCC = (LONG_OCC > SHORT_OCC) ? LONG_OCC : SHORT_OCC;
  localparam int OCC_W   = $clog2(MAX_OCC + 1);

  rejoin_state_e st_q, st_d;
  rejoin_cause_e cause_q, cause_d;
  logic          run_en, cnt_clr, occ_tick, occ_hit;
  logic [OCC_W-1:0] target;

  assign cnt_clr = (st_q != ST_RECOVER);
  assign run_en  = bit_strobe_i && (st_q == ST_RECOVER);
  assign target  = (cause_q == CAUSE_LONG) ? OCC_W'(LONG_OCC) : OCC_W'(SHORT_OCC);

  can_idle_run #(.IDLE_BITS(IDLE_BITS)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (cnt_clr),
    .en_i      (run_en),
    .rx_bit_i  (rx_bit_i),
    .occ_tick_o(occ_tick)
  );

  can_occ_count #(.MAX_OCC(MAX_OCC)) u_occ (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .tick_i  (occ_tick),
    .target_i(target),
    .hit_o   (occ_hit)
  );

  always_comb begin
    st_d    = st_q;
    cause_d = cause_q;
    unique case (st_q)
      ST_HOLD:    if (!reset_mode_i) st_d = ST_RECOVER;
      ST_RECOVER: if (occ_hit)       st_d = ST_ONLINE;
      ST_ONLINE:  st_d = ST_ONLINE;
      default:    st_d = ST_HOLD;
    endcase
    if (reset_mode_i || bus_off_i) st_d = ST_HOLD;
    if (bus_off_i)                               cause_d = CAUSE_LONG;
    else if (reset_mode_i && (st_q != ST_HOLD))  cause_d = CAUSE_SHORT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HOLD;
      cause_q <= CAUSE_SHORT;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
    end
  end

  assign bus_on_o     = (st_q == ST_ONLINE);
  assign recovering_o = (st_q == ST_RECOVER);

  // R9
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_on_o, recovering_o}));

  // R7
  abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode_i |=> (!bus_on_o && !recovering_o));

  // R10
  busoff_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_i |=> !bus_on_o);

  // R2
  rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_on_o) |-> $past(bit_strobe_i && rx_bit_i));
endmodule

// File: tb/can_rejoin_seq_bench.sv
module can_rejoin_seq_bench;
  logic clk = 1'b0;
  logic rst_n, reset_mode, bus_off, strobe, rx;
  logic bus_on, recovering;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  can_rejoin_seq u_can_rejoin_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_mode_i(reset_mode),
    .bus_off_i   (bus_off),
    .bit_strobe_i(strobe),
    .rx_bit_i    (rx),
    .bus_on_o    (bus_on),
    .recovering_o(recovering)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk);
    strobe = 1'b1;
    rx     = b;
    @(negedge clk);
    strobe = 1'b0;
    rx     = ~b;
  endtask

  task automatic recessive(input int n);
    for (int i = 0; i < n; i++) sbit(1'b1);
  endtask

  task automatic sw_reset();
    @(negedge clk); reset_mode = 1'b1;
    @(negedge clk); reset_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_bus_off();
    @(negedge clk); bus_off = 1'b1;
    @(negedge clk); bus_off = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reset_mode = 1'b1; bus_off = 1'b0; strobe = 1'b0; rx = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bus_on in reset", bus_on, 1'b0);
    check("R1 recovering in reset", recovering, 1'b0);
    recessive(20);
    check("R1 bus_on held by reset mode", bus_on, 1'b0);
    check("R1 recovering held", recovering, 1'b0);

    @(negedge clk); reset_mode = 1'b0;
    @(negedge clk);
    check("R9 recovering after release", recovering, 1'b1);
    recessive(10);
    check("R2 ten bits not enough", bus_on, 1'b0);
    // R8: non-strobe cycles with toggling rx
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); rx = i[0];
    end
    check("R8 no progress without strobe", bus_on, 1'b0);
    recessive(1);
    check("R2 eleventh bit gives bus_on", bus_on, 1'b1);
    check("R9 recovering drops at bus_on", recovering, 1'b0);

    // R6 + R3 after software reset
    sw_reset();
    recessive(10); sbit(1'b0); recessive(10);
    check("R3 dominant restarts run", bus_on, 1'b0);
    recessive(1);
    check("R3 R6 fresh run completes", bus_on, 1'b1);

    // sweep of run lengths after software reset (R6)
    for (int k = 0; k <= 13; k++) begin
      sw_reset();
      recessive(k);
      check("R6 sweep single occurrence", bus_on, (k >= 11));
    end

    // R10 + R4 + R5 bus-off recovery
    pulse_bus_off();
    check("R10 bus_off drops bus_on", bus_on, 1'b0);
    for (int j = 0; j < 127; j++) begin
      recessive(11);
      if (j[0]) sbit(1'b0);
    end
    recessive(10);
    check("R4 R5 127 occurrences plus 10 bits", bus_on, 1'b0);
    check("R4 still recovering", recovering, 1'b1);
    recessive(1);
    check("R4 R5 128th occurrence", bus_on, 1'b1);

    // R7 abandon mid-recovery
    pulse_bus_off();
    for (int j = 0; j < 50; j++) recessive(11);
    @(negedge clk); reset_mode = 1'b1;
    @(negedge clk);
    check("R7 recovering abandoned", recovering, 1'b0);
    check("R7 bus_on low", bus_on, 1'b0);
    recessive(11);
    check("R7 R1 no progress while held", bus_on, 1'b0);
    reset_mode = 1'b0;
    @(negedge clk);
    recessive(10);
    check("R7 no carried occurrences", bus_on, 1'b0);
    recessive(1);
    check("R6 software reset during bus-off recovery", bus_on, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule